// File: doc/BRIEF.md
# Synchronous Offset-Paced Byte Transmitter

This block drives bytes onto a 9-bit parallel bus (eight data bits plus an odd parity bit) in synchronous transfer mode. It does not wait for the acknowledge of one byte before it strobes the next. Instead, a REQ pulse is issued for each byte on a fixed schedule, and the number of bytes that have been strobed but not yet acknowledged is held below a window. The window comes from the negotiated offset. Each falling edge of ACK gives back one byte of that window. When nothing is left to send and every byte has been acknowledged, the done flag rises.

The window is measured in credits. A credit covers one, two or four bytes, depending on the offset. The block holds at most five credits: a four-slot store plus one staged credit. Some of these are pre-filled according to the offset, so the free remainder times the group size gives the byte window. The period setting produces three delay fields, counted in 8 ns clocks: data set-up before REQ, REQ width, and recovery after REQ. A fast and a slow timing class fix the first two fields, and the recovery field takes up the rest of the byte budget. Bytes arrive on a valid/ready stream and wait in a small queue. Offset and period are sampled only while the block is quiet. Offset 0 is not a valid setting; callers use an asynchronous engine for that case.

Top module: `sync_req_tx`

## Requirements
- R1: Each strobed bus word carries the data byte in bits 7:0 and odd parity in bit 8, so the nine bits together hold an odd number of ones. Bytes go out in the order they were accepted.
- R2: The byte budget B is floor(period*4/8). If period <= 25, set-up d0=3 and width d1=5; otherwise d0=6 and d1=12. Recovery d2 = B-d0-d1-3, limited to the range 0..15.
- R3: REQ stays high for exactly d1+1 clocks. The bus word changes d0+1 clocks before REQ rises and does not change while REQ is high.
- R4: When data and credit are both available, consecutive REQ rising edges are d0+d1+d2+3 clocks apart.
- R5: Group size G and preload P follow from the offset. Offset <= 4: G=1, P=5-offset. Offset <= 8: G=2, P=5-offset/2. Offset <= 16: G=4, P=5-offset/4. Larger offsets: G=4, P=0. P is then capped at 3.
- R6: The number of bytes strobed but not acknowledged never exceeds (5-P)*G. When that limit is reached, the transmitter stalls.
- R7: ACK passes through a two-flop synchroniser, and each falling edge acknowledges one byte. An ACK edge when nothing is outstanding is ignored.
- R8: done is high exactly when the queue is empty, no byte cycle is in progress and every strobed byte has been acknowledged. The final ACK also releases a partly used credit group.
- R9: Offset and period are taken in only while nothing is outstanding and no byte cycle runs. A change at any other time has no effect until that point.
- R10: After reset, REQ is 0, the bus is 0, done is 1 and tx_ready is 1.
- R11: A byte is accepted on a clock where tx_valid and tx_ready are both high. tx_ready falls when the FIFO_DEPTH-entry queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 8 ns period assumed for timing |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Queue can take a byte |
| sync_offset | input | OFS_W | Negotiated offset, 1 or more |
| sync_period | input | PER_W | Negotiated period setting |
| ack_in | input | 1 | Asynchronous ACK from the target, counted on its falling edge |
| bus_out | output | DATA_W+1 | Parity and data driven onto the bus |
| req_out | output | 1 | REQ strobe |
| done | output | 1 | All bytes sent and acknowledged |

## Verification
A byte launched at a clock edge changes the bus at that edge. REQ rises d0+1 edges later and falls d1+1 edges after that, and the next launch comes d2+1 edges later still. An ACK falling edge takes effect on the credit state two edges after the first flop samples it. The bench drives inputs and samples outputs at falling clock edges. It measures set-up, width and spacing with cycle counters started at the observed edges, so every expectation is an exact clock count. Stall limits are checked only after a wait longer than the full window at the chosen period. Completion is checked by polling done after the last acknowledge.

// File: rtl/sync_tx_pkg.sv
// Shared types and constants for the synchronous offset-paced transmitter.
// Assumes a 4-bit delay field is enough for every timing class.
package sync_tx_pkg;

    localparam int unsigned FAST_MAX_PERIOD = 25;
    localparam int unsigned FAST_SETUP      = 3;
    localparam int unsigned FAST_STROBE     = 5;
    localparam int unsigned SLOW_SETUP      = 6;
    localparam int unsigned SLOW_STROBE     = 12;
    localparam int unsigned CYCLE_OVERHEAD  = 3;
    localparam int unsigned DELAY_MAX       = 15;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [3:0] d_setup;
        logic [3:0] d_strobe;
        logic [3:0] d_hold;
    } req_timing_t;

endpackage

// File: rtl/sync_tx_cfg.sv
// Derives the REQ timing fields and the credit window from period and
// offset, and holds them in registers. New values are taken in only
// while 'sample' is high.
// Assumes: SLOTS+1 fits in WIN_W bits and offset 0 is never used.
module sync_tx_cfg
    import sync_tx_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int PER_W = 8,
    parameter int SLOTS = 4,
    parameter int WIN_W = 3,
    parameter int GRP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [OFS_W-1:0]  offset,
    input  logic [PER_W-1:0]  period,
    output req_timing_t       timing,
    output logic [GRP_W-1:0]  grp,
    output logic [WIN_W-1:0]  window
);
    localparam int CAP     = SLOTS + 1;
    localparam int PRE_MAX = SLOTS - 1;
    localparam int EXT_W   = PER_W + 2;

    req_timing_t      tim_d;
    logic [GRP_W-1:0] grp_d;
    logic [WIN_W-1:0] win_d;

    logic [EXT_W-1:0] budget;
    logic [EXT_W-1:0] need;
    logic [EXT_W-1:0] slack;
    logic             fast;
    logic [OFS_W-1:0] quot;
    logic [OFS_W-1:0] pre_raw;
    logic [OFS_W-1:0] pre;

    // Timing fields: set-up/width by speed class, recovery from the remaining budget
    always_comb begin
        fast            = (period <= PER_W'(FAST_MAX_PERIOD));
        tim_d.d_setup   = fast ? 4'(FAST_SETUP)  : 4'(SLOW_SETUP);
        tim_d.d_strobe  = fast ? 4'(FAST_STROBE) : 4'(SLOW_STROBE);
        budget          = EXT_W'(period >> 1);
        need            = EXT_W'(tim_d.d_setup) + EXT_W'(tim_d.d_strobe)
                        + EXT_W'(CYCLE_OVERHEAD);
        slack           = budget - need;
        if (budget <= need) begin
            tim_d.d_hold = 4'd0;
        end else if (slack > EXT_W'(DELAY_MAX)) begin
            tim_d.d_hold = 4'(DELAY_MAX);
        end else begin
            tim_d.d_hold = slack[3:0];
        end
    end

    // Credit mapping: group size and preload from the offset, preload capped
    always_comb begin
        if (offset <= OFS_W'(4)) begin
            grp_d = GRP_W'(1);
            quot  = offset;
        end else if (offset <= OFS_W'(8)) begin
            grp_d = GRP_W'(2);
            quot  = offset >> 1;
        end else if (offset <= OFS_W'(16)) begin
            grp_d = GRP_W'(4);
            quot  = offset >> 2;
        end else begin
            grp_d = GRP_W'(4);
            quot  = OFS_W'(CAP);
        end
        pre_raw = OFS_W'(CAP) - quot;
        pre     = (pre_raw > OFS_W'(PRE_MAX)) ? OFS_W'(PRE_MAX) : pre_raw;
        win_d   = WIN_W'(OFS_W'(CAP) - pre);
    end

    // Hold the derived values; refresh only when the engine is quiet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing <= '{d_setup: 4'(FAST_SETUP), d_strobe: 4'(FAST_STROBE), d_hold: 4'd0};
            grp    <= GRP_W'(1);
            window <= WIN_W'(CAP - PRE_MAX);
        end else if (sample) begin
            timing <= tim_d;
            grp    <= grp_d;
            window <= win_d;
        end
    end

endmodule

// File: rtl/sync_tx_fifo.sv
// Small first-in first-out queue for outgoing bytes, with a valid/ready
// write side and a pop-on-demand read side.
// Assumes rd_pop is asserted only while rd_avail is high.
module sync_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_valid,
    output logic         wr_ready,
    input  logic [W-1:0] wr_data,
    input  logic         rd_pop,
    output logic         rd_avail,
    output logic [W-1:0] rd_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [CW-1:0] cnt;
    logic          push;

    assign wr_ready = (cnt != CW'(DEPTH));
    assign rd_avail = (cnt != '0);
    assign push     = wr_valid && wr_ready;
    assign rd_data  = mem[rp];

    // Storage write
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= wr_data;
        end
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            end
            if (rd_pop) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            end
            case ({push, rd_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/sync_tx_credit.sv
// ACK synchroniser and credit keeper. A new credit is taken when the
// first byte of a group is launched. A credit comes back after the
// group's last acknowledge, or at the final acknowledge when a group was
// only partly used. Also tracks the count of unacknowledged bytes.
// Assumes grp is 1..MAX_GRP and window is 1..SLOTS+1.
module sync_tx_credit #(
    parameter int SLOTS   = 4,
    parameter int MAX_GRP = 4,
    parameter int WIN_W   = 3,
    parameter int GRP_W   = 3,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_raw,
    input  logic             launch,
    input  logic [GRP_W-1:0] grp,
    input  logic [WIN_W-1:0] window,
    output logic             credit_ok,
    output logic             quiet,
    output logic [WIN_W-1:0] excess,
    output logic [CNT_W-1:0] outstanding
);
    localparam int SUB_W = $clog2(MAX_GRP);

    logic             ack_meta;
    logic             ack_sync;
    logic             ack_prev;
    logic             ack_take;
    logic [SUB_W-1:0] sub_snd;
    logic [SUB_W-1:0] sub_ack;
    logic [SUB_W-1:0] n_snd;
    logic [SUB_W-1:0] n_ack;
    logic [WIN_W-1:0] n_exc;
    logic [CNT_W-1:0] n_out;

    // Two-flop synchroniser plus edge history for ACK
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_meta <= 1'b0;
            ack_sync <= 1'b0;
            ack_prev <= 1'b0;
        end else begin
            ack_meta <= ack_raw;
            ack_sync <= ack_meta;
            ack_prev <= ack_sync;
        end
    end

    assign ack_take  = ack_prev && !ack_sync && (outstanding != '0);
    assign credit_ok = (sub_snd != '0) || (excess < window);
    assign quiet     = (outstanding == '0);

    // Next credit state: apply the acknowledge first, then the launch
    always_comb begin
        n_out = outstanding;
        n_exc = excess;
        n_snd = sub_snd;
        n_ack = sub_ack;
        if (ack_take) begin
            if (outstanding == CNT_W'(1)) begin
                n_exc = '0;
                n_snd = '0;
                n_ack = '0;
            end else if (GRP_W'(sub_ack) + GRP_W'(1) == grp) begin
                n_ack = '0;
                n_exc = excess - WIN_W'(1);
            end else begin
                n_ack = sub_ack + SUB_W'(1);
            end
            n_out = outstanding - CNT_W'(1);
        end
        if (launch) begin
            if (n_snd == '0) begin
                n_exc = n_exc + WIN_W'(1);
            end
            if (GRP_W'(n_snd) + GRP_W'(1) == grp) begin
                n_snd = '0;
            end else begin
                n_snd = n_snd + SUB_W'(1);
            end
            n_out = n_out + CNT_W'(1);
        end
    end

    // Credit state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= '0;
            excess      <= '0;
            sub_snd     <= '0;
            sub_ack     <= '0;
        end else begin
            outstanding <= n_out;
            excess      <= n_exc;
            sub_snd     <= n_snd;
            sub_ack     <= n_ack;
        end
    end

endmodule

// File: rtl/sync_tx_seq.sv
// REQ sequencer. Each byte cycle has a set-up phase with REQ low, a
// strobe phase with REQ high and a hold phase with REQ low. Each phase
// lasts its delay field plus one clock. A new byte can start in the last
// clock of the hold phase, so bytes run back to back.
// Assumes the timing fields stay constant during a byte cycle.
module sync_tx_seq
    import sync_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  req_timing_t       timing,
    input  logic              data_avail,
    input  logic              credit_ok,
    input  logic [DATA_W-1:0] byte_in,
    output logic              launch,
    output logic              idle,
    output logic              req,
    output logic [DATA_W:0]   bus
);
    phase_e     ph;
    logic [3:0] cnt;
    logic       at_end;
    logic       slot_free;

    assign at_end    = (cnt == 4'd0);
    assign slot_free = (ph == PH_IDLE) || ((ph == PH_HOLD) && at_end);
    assign launch    = slot_free && data_avail && credit_ok;
    assign idle      = (ph == PH_IDLE);

    // Phase stepping, REQ generation and bus word load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= 4'd0;
            req <= 1'b0;
            bus <= '0;
        end else if (launch) begin
            bus <= {~^byte_in, byte_in};
            ph  <= PH_SETUP;
            cnt <= timing.d_setup;
        end else begin
            case (ph)
                PH_SETUP: begin
                    if (at_end) begin
                        ph  <= PH_STROBE;
                        req <= 1'b1;
                        cnt <= timing.d_strobe;
                    end else begin
                        cnt <= cnt - 4'd1;
                    end
                end
                PH_STROBE: begin
                    if (at_end) begin
                        ph  <= PH_HOLD;
                        req <= 1'b0;
                        cnt <= timing.d_hold;
                    end else begin
                        cnt <= cnt - 4'd1;
                    end
                end
                PH_HOLD: begin
                    if (at_end) begin
                        ph <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 4'd1;
                    end
                end
                default: begin
                    ph <= PH_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/sync_req_tx.sv
// Top of the synchronous offset-paced transmitter. Connects the byte
// queue, the configuration holder, the credit keeper and the REQ
// sequencer, and forms the completion flag.
// Assumes offset >= 1 and an 8 ns clock for the timing fields.
module sync_req_tx
    import sync_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int OFS_W      = 8,
    parameter int PER_W      = 8,
    parameter int SLOTS      = 4,
    parameter int MAX_GRP    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [OFS_W-1:0]  sync_offset,
    input  logic [PER_W-1:0]  sync_period,
    input  logic              ack_in,
    output logic [DATA_W:0]   bus_out,
    output logic              req_out,
    output logic              done
);
    localparam int WIN_W = $clog2(SLOTS + 2);
    localparam int GRP_W = $clog2(MAX_GRP + 1);
    localparam int CNT_W = $clog2((SLOTS + 1) * MAX_GRP + 1);

    req_timing_t       cfg_timing;
    logic [GRP_W-1:0]  cfg_grp;
    logic [WIN_W-1:0]  cfg_window;
    logic [WIN_W-1:0]  cr_excess;
    logic [CNT_W-1:0]  cr_outstanding;
    logic              cr_ok;
    logic              cr_quiet;
    logic              q_avail;
    logic [DATA_W-1:0] q_data;
    logic              seq_launch;
    logic              seq_idle;
    logic              cfg_sample;

    // Take in new settings only when no byte is in flight
    assign cfg_sample = cr_quiet && seq_idle && !seq_launch;
    // Completion: nothing queued, nothing strobing, nothing owed
    assign done       = !q_avail && seq_idle && cr_quiet;

    sync_tx_fifo #(
        .W     (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (tx_valid),
        .wr_ready (tx_ready),
        .wr_data  (tx_data),
        .rd_pop   (seq_launch),
        .rd_avail (q_avail),
        .rd_data  (q_data)
    );

    sync_tx_cfg #(
        .OFS_W (OFS_W),
        .PER_W (PER_W),
        .SLOTS (SLOTS),
        .WIN_W (WIN_W),
        .GRP_W (GRP_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (cfg_sample),
        .offset (sync_offset),
        .period (sync_period),
        .timing (cfg_timing),
        .grp    (cfg_grp),
        .window (cfg_window)
    );

    sync_tx_credit #(
        .SLOTS   (SLOTS),
        .MAX_GRP (MAX_GRP),
        .WIN_W   (WIN_W),
        .GRP_W   (GRP_W),
        .CNT_W   (CNT_W)
    ) u_credit (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_raw     (ack_in),
        .launch      (seq_launch),
        .grp         (cfg_grp),
        .window      (cfg_window),
        .credit_ok   (cr_ok),
        .quiet       (cr_quiet),
        .excess      (cr_excess),
        .outstanding (cr_outstanding)
    );

    sync_tx_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .timing     (cfg_timing),
        .data_avail (q_avail),
        .credit_ok  (cr_ok),
        .byte_in    (q_data),
        .launch     (seq_launch),
        .idle       (seq_idle),
        .req        (req_out),
        .bus        (bus_out)
    );

endmodule

// File: rtl/sync_req_tx_chk.sv
// Property checker for the transmitter, attached to the top by bind.
module sync_req_tx_chk #(
    parameter int DATA_W = 8,
    parameter int WIN_W  = 3,
    parameter int GRP_W  = 3,
    parameter int CNT_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic [DATA_W:0]  bus,
    input logic             done,
    input logic [WIN_W-1:0] excess,
    input logic [WIN_W-1:0] window,
    input logic [GRP_W-1:0] grp,
    input logic [CNT_W-1:0] outstanding
);

    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        excess <= window); // R6

    AST_BYTE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outstanding) <= int'(window) * int'(grp)); // R6

    AST_BUS_HELD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(req)) |-> $stable(bus)); // R3

    AST_SETUP_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $stable(bus)); // R3

    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req); // R8

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding != '0) |-> ($stable(window) && $stable(grp))); // R9

endmodule

bind sync_req_tx sync_req_tx_chk #(
    .DATA_W (DATA_W),
    .WIN_W  (WIN_W),
    .GRP_W  (GRP_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req_out),
    .bus         (bus_out),
    .done        (done),
    .excess      (cr_excess),
    .window      (cfg_window),
    .grp         (cfg_grp),
    .outstanding (cr_outstanding)
);

// File: tb/sync_req_tx_tb.sv
`timescale 1ns/1ps
module sync_req_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] sync_offset = 8'd4;
    logic [7:0] sync_period = 8'd50;
    logic       ack_in;
    logic [8:0] bus_out;
    logic       req_out;
    logic       done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int  feed_total = 0;
    int  feed_sent  = 0;
    bit  rdy_q      = 1'b0;
    int  rises      = 0;
    int  acks_done  = 0;
    int  ack_ph     = 0;
    bit  ack_en     = 1'b0;
    bit  ack_auto   = 1'b0;
    bit  ack_force  = 1'b0;
    bit  req_q      = 1'b0;
    logic [8:0] bus_q = '0;
    int  bus_chg_cyc = 0;
    int  rise_cyc    = 0;
    int  hi_cnt      = 0;
    int  last_high   = 0;
    int  last_gap    = 0;
    int  last_setup  = 0;

    assign ack_in = ack_auto | ack_force;

    always #4 clk = ~clk;

    sync_req_tx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .sync_offset (sync_offset),
        .sync_period (sync_period),
        .ack_in      (ack_in),
        .bus_out     (bus_out),
        .req_out     (req_out),
        .done        (done)
    );

    function automatic logic [7:0] byte_of(int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    function automatic logic [8:0] word_of(int i);
        logic [7:0] b = byte_of(i);
        int ones = 0;
        for (int k = 0; k < 8; k++) ones += b[k];
        return {((ones % 2) == 0) ? 1'b1 : 1'b0, b};
    endfunction

    function automatic int e_grp(int o);
        if (o <= 4) return 1;
        if (o <= 8) return 2;
        return 4;
    endfunction

    function automatic int e_pre(int o);
        int p;
        if (o <= 4)       p = 5 - o;
        else if (o <= 8)  p = 5 - o / 2;
        else if (o <= 16) p = 5 - o / 4;
        else              p = 0;
        return (p > 3) ? 3 : p;
    endfunction

    function automatic int e_d0(int p); return (p <= 25) ? 3 : 6;  endfunction
    function automatic int e_d1(int p); return (p <= 25) ? 5 : 12; endfunction
    function automatic int e_d2(int p);
        int d = (p * 4 / 8) - e_d0(p) - e_d1(p) - 3;
        if (d < 0)  d = 0;
        if (d > 15) d = 15;
        return d;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Stream feeder: offers bytes in index order until feed_total is reached
    always @(negedge clk) begin
        if (tx_valid && rdy_q) feed_sent++;
        tx_valid = (feed_sent < feed_total);
        tx_data  = byte_of(feed_sent);
        rdy_q    = tx_ready;
    end

    // Bus monitor: data at each strobe, set-up, width and spacing counters
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (bus_out != bus_q) bus_chg_cyc = cyc;
            if (req_out && !req_q) begin
                chk(bus_out == word_of(rises), "R1 bus word", int'(bus_out), int'(word_of(rises)));
                last_setup = cyc - bus_chg_cyc;
                last_gap   = cyc - rise_cyc;
                rise_cyc   = cyc;
                rises++;
                hi_cnt = 1;
            end else if (req_out) begin
                hi_cnt++;
            end
            if (!req_out && req_q) last_high = hi_cnt;
            req_q = req_out;
            bus_q = bus_out;
        end
    end

    // Target model: one ACK pulse (2 clocks high, 2 low) per observed strobe
    always @(negedge clk) begin
        case (ack_ph)
            0: if (ack_en && rises > acks_done) begin ack_auto = 1'b1; ack_ph = 1; end
            1: ack_ph = 2;
            2: begin ack_auto = 1'b0; acks_done++; ack_ph = 3; end
            default: ack_ph = 0;
        endcase
    end

    task automatic wait_done(string tag);
        int t = 0;
        while (feed_sent < feed_total) @(negedge clk);
        while (!done && t < 8000) begin @(negedge clk); t++; end
        chk(done == 1'b1, tag, int'(done), 1);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int per_list[10] = '{0, 20, 25, 26, 40, 50, 51, 64, 100, 255};
        int ofs_list[21] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15, 16, 17, 18, 19, 20, 40};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(req_out == 1'b0, "R10 req", int'(req_out), 0);
        chk(bus_out == 9'd0, "R10 bus", int'(bus_out), 0);
        chk(done == 1'b1, "R10 done", int'(done), 1);
        chk(tx_ready == 1'b1, "R10 tx_ready", int'(tx_ready), 1);

        // R2 R3 R4: timing over a sweep of period settings
        foreach (per_list[i]) begin
            int p = per_list[i];
            sync_period = 8'(p);
            sync_offset = 8'd4;
            ack_en = 1'b1;
            repeat (4) @(negedge clk);
            feed_total += 3;
            wait_done("R8 done after timed burst");
            chk(last_high == e_d1(p) + 1, "R3 strobe width", last_high, e_d1(p) + 1);
            chk(last_setup == e_d0(p) + 1, "R3 set-up", last_setup, e_d0(p) + 1);
            chk(last_gap == e_d0(p) + e_d1(p) + e_d2(p) + 3, "R2 R4 spacing",
                last_gap, e_d0(p) + e_d1(p) + e_d2(p) + 3);
        end

        // R7: ACK edges with nothing outstanding are ignored
        ack_en = 1'b0;
        sync_period = 8'd50;
        repeat (2) begin
            ack_force = 1'b1; repeat (3) @(negedge clk);
            ack_force = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(done == 1'b1, "R7 spurious ack", int'(done), 1);

        // R5 R6 R8 R9 R11: window per offset, stall, then drain
        foreach (ofs_list[i]) begin
            int o  = ofs_list[i];
            int w  = (5 - e_pre(o)) * e_grp(o);
            int ex = (w < 24) ? w : 24;
            int r0;
            sync_offset = 8'(o);
            ack_en = 1'b0;
            repeat (4) @(negedge clk);
            r0 = rises;
            feed_total += 24;
            repeat (700) @(negedge clk);
            chk(rises - r0 == ex, "R5 R6 stall window", rises - r0, ex);
            chk(done == 1'b0, "R8 done while owed", int'(done), 0);
            chk(tx_ready == 1'b0, "R11 queue full", int'(tx_ready), 0);
            if (o == 4) begin
                sync_offset = 8'd16;
                repeat (300) @(negedge clk);
                chk(rises - r0 == ex, "R9 offset change while busy", rises - r0, ex);
                sync_offset = 8'd4;
            end
            ack_en = 1'b1;
            wait_done("R8 done after drain");
            chk(rises - r0 == 24, "R6 all bytes sent", rises - r0, 24);
        end

        // R8: partly used credit groups are released by the last ACK
        sync_offset = 8'd8;
        repeat (4) @(negedge clk);
        feed_total += 3;
        wait_done("R8 partial group of 2");
        sync_offset = 8'd12;
        repeat (4) @(negedge clk);
        feed_total += 5;
        wait_done("R8 partial group of 4");
        chk(rises == feed_total, "R1 strobe count", rises, feed_total);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule